// File: doc/BRIEF.md
# Integer Execute Unit with Multiply-High

This block is the integer execute stage of a 32-bit load/store core. Each accepted operation carries a decoded major opcode, a six-bit function code for register-register work, two register operands (`rs` and `rt`), a 16-bit immediate and a 5-bit shift amount. The block produces one 32-bit result. The supported operations are add, subtract, bitwise logic, signed and unsigned set-less-than, three shift forms, an add of an upper immediate, and three multiply variants. Each multiply returns its 32-bit slice straight into the result, with no separate high/low register pair.

Operations arrive on a valid/ready stream and results leave on a second valid/ready stream, through a single output register. The input is ready whenever that register is empty or is being drained in the same cycle. A result is therefore due on the cycle after its operation is accepted. While the consumer holds `out_ready` low, the register keeps its contents and `in_ready` stays low. All arithmetic wraps modulo 2^32 and nothing traps. An opcode or function code the block does not know yields a zero result with an illegal flag set.

Top module: `exe_int_unit`

## Requirements
- R1: An operation is accepted on a rising edge where `in_valid` and `in_ready` are both high, and its result appears with `out_valid` high after that edge. `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_result` and `out_illegal` hold their values.
- R2: While `rst_n` is low, `out_valid`, `out_result` and `out_illegal` are 0.
- R3: Function 100001 (opcode 00000) gives rs+rt and function 100011 gives rs-rt. Opcode 01001 gives rs plus the sign-extended immediate. All three wrap modulo 2^32.
- R4: With opcode 00000, function 100100 gives rs&rt and function 100110 gives rs^rt. Opcodes 01100, 01101 and 01110 give rs AND, OR and XOR with the zero-extended immediate.
- R5: Function 101010 gives 1 when rs<rt as signed values and 0 otherwise. Function 101011 does the same comparison as unsigned values. Opcode 01010 gives 1 when rs is below the sign-extended immediate, compared as signed values.
- R6: Opcode 01011 sign-extends the immediate, compares rs against it as unsigned values, and gives 1 or 0.
- R7: Opcode 01111 gives rs + (imm << 16).
- R8: Function 000000 shifts rt left by `in_shamt`. Function 000100 shifts rt left by rs[4:0] and function 000110 shifts rt right logically by rs[4:0]. Bits 31:5 of rs have no effect on either of these two.
- R9: Function 101000 gives bits 63:32 of the signed 64-bit product rs*rt.
- R10: Function 101001 gives bits 63:32 of the unsigned 64-bit product rs*rt.
- R11: Function 101100 gives bits 31:0 of the product rs*rt.
- R12: An opcode outside {00000, 01001..01111}, or opcode 00000 with a function code not listed in R3 to R11, gives a result of 0 with `out_illegal` high. Every listed operation gives `out_illegal` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present on the input stream |
| in_ready | output | 1 | Block can take an operation this cycle |
| in_opcode | input | 5 | Major opcode |
| in_funct | input | 6 | Function code, used when opcode is 00000 |
| in_rs | input | 32 | First register operand |
| in_rt | input | 32 | Second register operand |
| in_imm | input | 16 | Immediate field |
| in_shamt | input | 5 | Shift amount for the fixed left shift |
| out_valid | output | 1 | Result present on the output stream |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 32 | Operation result |
| out_illegal | output | 1 | Operation was not recognised |

## Verification
Every result is due exactly one rising edge after its operation is accepted, because the only register on the path is the output register. The bench drives each operation on a falling edge, lets one rising edge accept it, and reads `out_result` and `out_illegal` on the next falling edge. It compares them there with a behavioural model written from the requirements. For the stall case the bench holds `out_ready` low across extra rising edges and checks, on each falling edge, that the held result and the low `in_ready` have not changed. It then releases `out_ready` and expects the waiting operation one edge later.

// File: rtl/exe_int_pkg.sv
package exe_int_pkg;
  typedef enum logic [4:0] {
    OPC_REG   = 5'b00000,
    OPC_ADDI  = 5'b01001,
    OPC_SLTI  = 5'b01010,
    OPC_SLTIU = 5'b01011,
    OPC_ANDI  = 5'b01100,
    OPC_ORI   = 5'b01101,
    OPC_XORI  = 5'b01110,
    OPC_AUI   = 5'b01111
  } opc_e;

  typedef enum logic [5:0] {
    FN_SLL   = 6'b000000,
    FN_SLLV  = 6'b000100,
    FN_SRLV  = 6'b000110,
    FN_ADD   = 6'b100001,
    FN_SUB   = 6'b100011,
    FN_AND   = 6'b100100,
    FN_XOR   = 6'b100110,
    FN_MULH  = 6'b101000,
    FN_MULHU = 6'b101001,
    FN_SLT   = 6'b101010,
    FN_SLTU  = 6'b101011,
    FN_MULL  = 6'b101100
  } fn_e;

  typedef enum logic [3:0] {
    SEL_ADD, SEL_AND, SEL_OR, SEL_XOR, SEL_LTS, SEL_LTU,
    SEL_SHL, SEL_SHR, SEL_MULHS, SEL_MULHU, SEL_MULLO, SEL_ZERO
  } res_sel_e;

  typedef enum logic [1:0] {
    OPB_RT, OPB_SEXT, OPB_ZEXT, OPB_UPPER
  } opb_sel_e;

  typedef struct packed {
    res_sel_e res_sel;
    opb_sel_e opb_sel;
    logic     subtract;
    logic     amt_from_rs;
    logic     illegal;
  } dec_t;
endpackage

// File: rtl/exe_arith.sv
module exe_arith #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         subtract,
  output logic [W-1:0] sum,
  output logic [W-1:0] and_o,
  output logic [W-1:0] or_o,
  output logic [W-1:0] xor_o,
  output logic         lt_s,
  output logic         lt_u
);
  logic [W-1:0] b_eff;

  always_comb begin
    b_eff = subtract ? ~b : b;
    sum   = a + b_eff + {{(W-1){1'b0}}, subtract};
    and_o = a & b;
    or_o  = a | b;
    xor_o = a ^ b;
    lt_s  = $signed(a) < $signed(b);
    lt_u  = a < b;
  end
endmodule

// File: rtl/exe_shift.sv
module exe_shift #(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  val,
  input  logic [AW-1:0] amt,
  output logic [W-1:0]  shl,
  output logic [W-1:0]  shr
);
  always_comb begin
    shl = val << amt;
    shr = val >> amt;
  end
endmodule

// File: rtl/exe_mul.sv
module exe_mul #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] hi_s,
  output logic [W-1:0] hi_u,
  output logic [W-1:0] lo
);
  logic [2*W-1:0] prod_u;
  logic [W-1:0]   corr_a;
  logic [W-1:0]   corr_b;

  always_comb begin
    prod_u = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    corr_a = a[W-1] ? b : '0;
    corr_b = b[W-1] ? a : '0;
    hi_u   = prod_u[2*W-1:W];
    lo     = prod_u[W-1:0];
    hi_s   = prod_u[2*W-1:W] - corr_a - corr_b;
  end
endmodule

// File: rtl/exe_int_unit.sv
module exe_int_unit #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [4:0]        in_opcode,
  input  logic [5:0]        in_funct,
  input  logic [DATA_W-1:0] in_rs,
  input  logic [DATA_W-1:0] in_rt,
  input  logic [IMM_W-1:0]  in_imm,
  input  logic [$clog2(DATA_W)-1:0] in_shamt,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic              out_illegal
);
  import exe_int_pkg::*;

  localparam int SH_W = $clog2(DATA_W);
  localparam int UP_S = DATA_W - IMM_W;

  dec_t              dec;
  logic [DATA_W-1:0] opb;
  logic [SH_W-1:0]   amt;
  logic [DATA_W-1:0] sum, and_r, or_r, xor_r, shl, shr, mhs, mhu, mlo;
  logic              lt_s, lt_u;
  logic [DATA_W-1:0] result;

  always_comb begin
    dec = '{res_sel: SEL_ZERO, opb_sel: OPB_RT, subtract: 1'b0,
            amt_from_rs: 1'b0, illegal: 1'b0};
    unique case (in_opcode)
      OPC_REG: begin
        unique case (in_funct)
          FN_ADD:   dec.res_sel = SEL_ADD;
          FN_SUB:   begin dec.res_sel = SEL_ADD; dec.subtract = 1'b1; end
          FN_AND:   dec.res_sel = SEL_AND;
          FN_XOR:   dec.res_sel = SEL_XOR;
          FN_SLT:   dec.res_sel = SEL_LTS;
          FN_SLTU:  dec.res_sel = SEL_LTU;
          FN_SLL:   dec.res_sel = SEL_SHL;
          FN_SLLV:  begin dec.res_sel = SEL_SHL; dec.amt_from_rs = 1'b1; end
          FN_SRLV:  begin dec.res_sel = SEL_SHR; dec.amt_from_rs = 1'b1; end
          FN_MULH:  dec.res_sel = SEL_MULHS;
          FN_MULHU: dec.res_sel = SEL_MULHU;
          FN_MULL:  dec.res_sel = SEL_MULLO;
          default:  dec.illegal = 1'b1;
        endcase
      end
      OPC_ADDI:  begin dec.res_sel = SEL_ADD; dec.opb_sel = OPB_SEXT;  end
      OPC_SLTI:  begin dec.res_sel = SEL_LTS; dec.opb_sel = OPB_SEXT;  end
      OPC_SLTIU: begin dec.res_sel = SEL_LTU; dec.opb_sel = OPB_SEXT;  end
      OPC_ANDI:  begin dec.res_sel = SEL_AND; dec.opb_sel = OPB_ZEXT;  end
      OPC_ORI:   begin dec.res_sel = SEL_OR;  dec.opb_sel = OPB_ZEXT;  end
      OPC_XORI:  begin dec.res_sel = SEL_XOR; dec.opb_sel = OPB_ZEXT;  end
      OPC_AUI:   begin dec.res_sel = SEL_ADD; dec.opb_sel = OPB_UPPER; end
      default:   dec.illegal = 1'b1;
    endcase
  end

  always_comb begin
    unique case (dec.opb_sel)
      OPB_SEXT:  opb = {{UP_S{in_imm[IMM_W-1]}}, in_imm};
      OPB_ZEXT:  opb = {{UP_S{1'b0}}, in_imm};
      OPB_UPPER: opb = {in_imm, {UP_S{1'b0}}};
      default:   opb = in_rt;
    endcase
    amt = dec.amt_from_rs ? in_rs[SH_W-1:0] : in_shamt;
  end

  exe_arith #(.W(DATA_W)) u_arith (
    .a(in_rs), .b(opb), .subtract(dec.subtract), .sum(sum),
    .and_o(and_r), .or_o(or_r), .xor_o(xor_r), .lt_s(lt_s), .lt_u(lt_u)
  );

  exe_shift #(.W(DATA_W), .AW(SH_W)) u_shift (
    .val(in_rt), .amt(amt), .shl(shl), .shr(shr)
  );

  exe_mul #(.W(DATA_W)) u_mul (
    .a(in_rs), .b(in_rt), .hi_s(mhs), .hi_u(mhu), .lo(mlo)
  );

  always_comb begin
    unique case (dec.res_sel)
      SEL_ADD:   result = sum;
      SEL_AND:   result = and_r;
      SEL_OR:    result = or_r;
      SEL_XOR:   result = xor_r;
      SEL_LTS:   result = {{(DATA_W-1){1'b0}}, lt_s};
      SEL_LTU:   result = {{(DATA_W-1){1'b0}}, lt_u};
      SEL_SHL:   result = shl;
      SEL_SHR:   result = shr;
      SEL_MULHS: result = mhs;
      SEL_MULHU: result = mhu;
      SEL_MULLO: result = mlo;
      default:   result = '0;
    endcase
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_illegal <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result  <= result;
        out_illegal <= dec.illegal;
      end
    end
  end
endmodule

// File: rtl/exe_int_unit_chk.sv
module exe_int_unit_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [4:0]        in_opcode,
  input logic [5:0]        in_funct,
  input logic [DATA_W-1:0] in_rs,
  input logic [DATA_W-1:0] in_rt,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_result,
  input logic              out_illegal
);
  logic accept;
  assign accept = in_valid && in_ready;

  p_hold_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_illegal));

  p_accept_shows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  p_stall_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_reset_idle_r2: assert property (@(posedge clk)
    !rst_n |=> !out_valid && out_result == '0);

  p_cmp_bool_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (in_opcode == 5'b01010 || in_opcode == 5'b01011)
    |=> out_result[DATA_W-1:1] == '0 && !out_illegal);

  p_low_product_r11: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_opcode == 5'b00000 && in_funct == 6'b101100
    |=> out_result == $past(in_rs * in_rt));

  p_illegal_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> out_result == '0);
endmodule

bind exe_int_unit exe_int_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_opcode(in_opcode), .in_funct(in_funct), .in_rs(in_rs), .in_rt(in_rt),
  .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
  .out_illegal(out_illegal)
);

// File: tb/exe_int_unit_tb.sv
`timescale 1ns/1ps
module exe_int_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [4:0]  in_opcode = '0;
  logic [5:0]  in_funct = '0;
  logic [31:0] in_rs = '0;
  logic [31:0] in_rt = '0;
  logic [15:0] in_imm = '0;
  logic [4:0]  in_shamt = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic        out_illegal;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  exe_int_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_opcode(in_opcode), .in_funct(in_funct), .in_rs(in_rs), .in_rt(in_rt),
    .in_imm(in_imm), .in_shamt(in_shamt), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_illegal(out_illegal)
  );

  function automatic logic [32:0] model(input logic [4:0] op, input logic [5:0] fn,
                                        input logic [31:0] a, input logic [31:0] b,
                                        input logic [15:0] im, input logic [4:0] sh);
    logic [31:0] se, ze;
    longint      ps;
    logic [63:0] pu;
    se = {{16{im[15]}}, im};
    ze = {16'h0, im};
    ps = longint'($signed(a)) * longint'($signed(b));
    pu = {32'h0, a} * {32'h0, b};
    case (op)
      5'b00000: case (fn)
        6'b100001: return {1'b0, a + b};
        6'b100011: return {1'b0, a - b};
        6'b100100: return {1'b0, a & b};
        6'b100110: return {1'b0, a ^ b};
        6'b101010: return {1'b0, 31'h0, $signed(a) < $signed(b)};
        6'b101011: return {1'b0, 31'h0, a < b};
        6'b000000: return {1'b0, b << sh};
        6'b000100: return {1'b0, b << a[4:0]};
        6'b000110: return {1'b0, b >> a[4:0]};
        6'b101000: return {1'b0, ps[63:32]};
        6'b101001: return {1'b0, pu[63:32]};
        6'b101100: return {1'b0, pu[31:0]};
        default:   return {1'b1, 32'h0};
      endcase
      5'b01001: return {1'b0, a + se};
      5'b01010: return {1'b0, 31'h0, $signed(a) < $signed(se)};
      5'b01011: return {1'b0, 31'h0, a < se};
      5'b01100: return {1'b0, a & ze};
      5'b01101: return {1'b0, a | ze};
      5'b01110: return {1'b0, a ^ ze};
      5'b01111: return {1'b0, a + {im, 16'h0}};
      default:  return {1'b1, 32'h0};
    endcase
  endfunction

  task automatic check(input string req, input logic [32:0] act, input logic [32:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got ill=%0b res=%h, expected ill=%0b res=%h",
               req, act[32], act[31:0], exp[32], exp[31:0]);
    end
  endtask

  task automatic run_op(input string req, input logic [4:0] op, input logic [5:0] fn,
                        input logic [31:0] a, input logic [31:0] b,
                        input logic [15:0] im, input logic [4:0] sh);
    @(negedge clk);
    in_opcode = op; in_funct = fn; in_rs = a; in_rt = b; in_imm = im; in_shamt = sh;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(req, {!out_valid, 32'h0}, 33'h0);
    check(req, {out_illegal, out_result}, model(op, fn, a, b, im, sh));
  endtask

  task automatic t_reset;
    check("R2", {out_valid, out_illegal, in_ready, out_result}, {1'b0, 1'b0, 1'b1, 32'h0});
  endtask

  task automatic t_addsub;
    run_op("R3 add wrap", 5'b00000, 6'b100001, 32'hFFFF_FFFF, 32'h0000_0002, 16'h0, 5'd0);
    run_op("R3 sub wrap", 5'b00000, 6'b100011, 32'h0000_0001, 32'h0000_0003, 16'h0, 5'd0);
    run_op("R3 addi neg", 5'b01001, 6'b000000, 32'h0000_0010, 32'h0, 16'hFFF0, 5'd0);
  endtask

  task automatic t_logic;
    run_op("R4 and", 5'b00000, 6'b100100, 32'hF0F0_1234, 32'h0FF0_FF00, 16'h0, 5'd0);
    run_op("R4 xor", 5'b00000, 6'b100110, 32'hAAAA_5555, 32'hFFFF_0000, 16'h0, 5'd0);
    run_op("R4 andi zext", 5'b01100, 6'b0, 32'hFFFF_FFFF, 32'h0, 16'h8F0F, 5'd0);
    run_op("R4 ori zext", 5'b01101, 6'b0, 32'h1200_0000, 32'h0, 16'h8001, 5'd0);
    run_op("R4 xori zext", 5'b01110, 6'b0, 32'hFFFF_FFFF, 32'h0, 16'hFFFF, 5'd0);
  endtask

  task automatic t_slt;
    run_op("R5 slt signed", 5'b00000, 6'b101010, 32'hFFFF_FFFF, 32'h0000_0001, 16'h0, 5'd0);
    run_op("R5 sltu", 5'b00000, 6'b101011, 32'hFFFF_FFFF, 32'h0000_0001, 16'h0, 5'd0);
    run_op("R5 slti", 5'b01010, 6'b0, 32'hFFFF_FFFE, 32'h0, 16'hFFFF, 5'd0);
    run_op("R5 slti equal", 5'b01010, 6'b0, 32'h0000_0005, 32'h0, 16'h0005, 5'd0);
  endtask

  task automatic t_sltiu;
    run_op("R6 sltiu big imm", 5'b01011, 6'b0, 32'hFFFF_0000, 32'h0, 16'h8000, 5'd0);
    run_op("R6 sltiu false", 5'b01011, 6'b0, 32'hFFFF_9000, 32'h0, 16'h8000, 5'd0);
  endtask

  task automatic t_aui;
    run_op("R7 aui", 5'b01111, 6'b0, 32'h0000_1234, 32'h0, 16'hABCD, 5'd0);
    run_op("R7 aui wrap", 5'b01111, 6'b0, 32'hF000_0001, 32'h0, 16'h2000, 5'd0);
  endtask

  task automatic t_shift;
    run_op("R8 sll", 5'b00000, 6'b000000, 32'h0, 32'h8000_0003, 16'h0, 5'd4);
    run_op("R8 sllv upper rs ignored", 5'b00000, 6'b000100, 32'hFFFF_FFE3, 32'h0000_00F1, 16'h0, 5'd9);
    run_op("R8 srlv", 5'b00000, 6'b000110, 32'h0000_0021, 32'h8000_0000, 16'h0, 5'd0);
    run_op("R8 srlv by 31", 5'b00000, 6'b000110, 32'h0000_001F, 32'hFFFF_FFFF, 16'h0, 5'd0);
  endtask

  task automatic t_mul;
    run_op("R9 mulh neg*pos", 5'b00000, 6'b101000, 32'hFFFF_FFFE, 32'h0000_0003, 16'h0, 5'd0);
    run_op("R9 mulh min*min", 5'b00000, 6'b101000, 32'h8000_0000, 32'h8000_0000, 16'h0, 5'd0);
    run_op("R10 mulhu", 5'b00000, 6'b101001, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0, 5'd0);
    run_op("R10 mulhu small", 5'b00000, 6'b101001, 32'h0001_0000, 32'h0003_0000, 16'h0, 5'd0);
    run_op("R11 mull", 5'b00000, 6'b101100, 32'hFFFF_FFFE, 32'h0000_0003, 16'h0, 5'd0);
    run_op("R11 mull big", 5'b00000, 6'b101100, 32'h1234_5678, 32'h9ABC_DEF0, 16'h0, 5'd0);
  endtask

  task automatic t_illegal;
    run_op("R12 bad funct", 5'b00000, 6'b111111, 32'h1234_5678, 32'h1, 16'h0, 5'd0);
    run_op("R12 bad opcode", 5'b10101, 6'b100001, 32'h1234_5678, 32'h1, 16'hFFFF, 5'd0);
    run_op("R12 legal after illegal", 5'b00000, 6'b100001, 32'h1, 32'h1, 16'h0, 5'd0);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    out_ready = 1'b0;
    in_opcode = 5'b00000; in_funct = 6'b100001; in_rs = 32'd10; in_rt = 32'd20;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 first accepted", {out_valid, out_result}, {1'b1, 32'd30});
    check("R1 ready low when full", {32'h0, in_ready}, 33'h0);
    in_funct = 6'b100011; in_rs = 32'd50; in_rt = 32'd8;
    for (int i = 0; i < 2; i++) begin
      @(posedge clk);
      @(negedge clk);
      check("R1 held under stall", {in_ready, out_result}, {1'b0, 32'd30});
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 second after release", {out_valid, out_result}, {1'b1, 32'd42});
    @(posedge clk);
    @(negedge clk);
    check("R1 drained", {32'h0, out_valid}, 33'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_addsub();
    t_logic();
    t_slt();
    t_sltiu();
    t_aui();
    t_shift();
    t_mul();
    t_illegal();
    t_backpressure();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule